// File: doc/BRIEF.md
# Serial boot source detector

This block settles, once per reset, how the device starts. Two strap pins are captured on the first clock after reset is released and decoded into one of four boot modes. The block also reports whether code fetches at address zero go to the separate test area rather than to user flash, and it flags the reserved strap combination.

In the serial bootstrap mode the block watches a UART receive line and a CAN receive line at the same time. Both lines pass through two-flop synchronizers. Short dominant (low) glitches on the CAN line are discarded by a counting filter. A UART start condition has priority from the moment a CAN low pulse begins until that pulse ends with a valid rising edge. The first qualifying event picks the source. The choice is latched with a one-cycle done pulse and held until the next reset.

Top module: `boot_src_detect`

## Requirements
- R1: The strap pins are sampled only on the first rising clock edge after `rst_n` goes high; later strap changes leave `boot_mode` unchanged until the next reset.
- R2: Straps (`strap_hi`,`strap_lo`) = (1,1) give `boot_mode` = 0 (user mode), with `fetch_remap` = 0 and `strap_rsvd` = 0.
- R3: Straps (1,0) give `boot_mode` = 1 (serial bootstrap), with `fetch_remap` = 1.
- R4: Straps (0,1) give `boot_mode` = 2 (alternate boot), with `fetch_remap` equal to the inverse of `sig_ok`.
- R5: Straps (0,0) give `boot_mode` = 3 and `strap_rsvd` = 1.
- R6: Outside the serial bootstrap mode, `src_uart`, `src_can` and `sel_done` stay low whatever the receive lines do.
- R7: In bootstrap mode, a UART falling edge selects UART. If `uart_rx` is first sampled low at edge E, then `src_uart` is high and `sel_done` pulses after edge E+2, and not before.
- R8: A CAN low pulse covering fewer than 20 rising clock edges selects nothing.
- R9: A CAN low pulse covering 20 or more edges selects CAN when the line returns high, for any length: the filter count saturates and does not wrap. `src_can` rises two edges after the first edge at which the line is sampled high.
- R10: A UART falling edge seen during a CAN low pulse, or in the same cycle as its valid rising edge, selects UART and not CAN.
- R11: After a selection, `src_uart`/`src_can` stay fixed and at most one of them is high. `sel_done` is high for exactly one cycle, and later line activity has no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_hi | input | 1 | Upper boot strap pin |
| strap_lo | input | 1 | Lower boot strap pin |
| sig_ok | input | 1 | Signature check passed (alternate mode mapping) |
| uart_rx | input | 1 | UART receive line, idle high |
| can_rx | input | 1 | CAN receive line, idle high (recessive) |
| boot_mode | output | 2 | 0 user, 1 serial bootstrap, 2 alternate, 3 reserved |
| fetch_remap | output | 1 | Code fetches at address zero go to the test area |
| strap_rsvd | output | 1 | Reserved strap combination seen |
| src_uart | output | 1 | UART chosen as boot source |
| src_can | output | 1 | CAN chosen as boot source |
| sel_done | output | 1 | One-cycle pulse when a source is chosen |

## Verification
The hardest situation to reach from the ports is the moment where both rules apply at once: a CAN dominant pulse that has already passed the filter threshold ends in the same cycle that a UART start condition arrives. The bench reaches it by releasing `can_rx` and pulling `uart_rx` low on the same falling clock edge after a 25-cycle low pulse, so that both synchronized events reach the selector in one cycle. It then sets up the filter boundary cases separately: pulses of exactly 19 and 20 edges, and a 200-edge pulse that would wrap a counter that does not saturate.

// File: rtl/boot_src_pkg.sv
package boot_src_pkg;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SBOOT = 2'd1,
    MODE_ALT = 2'd2,
    MODE_RSVD = 2'd3
  } boot_mode_e;

  typedef enum logic [1:0] {
    SEL_WAIT,
    SEL_WATCH,
    SEL_DONE,
    SEL_OFF
  } sel_state_e;

  function automatic boot_mode_e decode_straps(input logic hi, input logic lo);
    case ({hi, lo})
      2'b11: decode_straps = MODE_USER;
      2'b10: decode_straps = MODE_SBOOT;
      2'b01: decode_straps = MODE_ALT;
      default: decode_straps = MODE_RSVD;
    endcase
  endfunction

  function automatic logic remap_for(input boot_mode_e m, input logic sig_good);
    case (m)
      MODE_SBOOT: remap_for = 1'b1;
      MODE_ALT: remap_for = ~sig_good;
      default: remap_for = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bsd_line_sync.sv
module bsd_line_sync #(
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic din,
  output logic level,
  output logic fell,
  output logic rose
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= IDLE;
          else chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= IDLE;
          else chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
  assign fell = chain[STAGES] & ~chain[STAGES-1];
  assign rose = ~chain[STAGES] & chain[STAGES-1];
endmodule

// File: rtl/bsd_dom_filter.sv
module bsd_dom_filter #(
  parameter int LIMIT = 20,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic line,
  input logic line_rose,
  output logic [CW-1:0] count,
  output logic saturated,
  output logic valid_rise
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (!enable || line) cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;

  assign count = cnt_q;
  assign saturated = (cnt_q == CW'(LIMIT));
  assign valid_rise = enable & line_rose & saturated;
endmodule

// File: rtl/bsd_strap_latch.sv
module bsd_strap_latch
  import boot_src_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic strap_hi,
  input logic strap_lo,
  output boot_mode_e mode,
  output logic captured,
  output logic capture_now
);
  boot_mode_e mode_q;
  logic cap_q;

  assign capture_now = ~cap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= MODE_USER;
      cap_q <= 1'b0;
    end else if (!cap_q) begin
      mode_q <= decode_straps(strap_hi, strap_lo);
      cap_q <= 1'b1;
    end

  assign mode = mode_q;
  assign captured = cap_q;
endmodule

// File: rtl/boot_src_detect.sv
module boot_src_detect
  import boot_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic strap_hi,
  input logic strap_lo,
  input logic sig_ok,
  input logic uart_rx,
  input logic can_rx,
  output logic [1:0] boot_mode,
  output logic fetch_remap,
  output logic strap_rsvd,
  output logic src_uart,
  output logic src_can,
  output logic sel_done
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  boot_mode_e mode;
  logic captured, capture_now;
  logic uart_lvl, uart_fell, uart_rose;
  logic can_lvl, can_fell, can_rose;
  logic [CW-1:0] filt_cnt;
  logic filt_sat, can_valid_rise;
  logic watching, pick_uart, pick_can;
  sel_state_e state_q, state_d;
  logic src_uart_q, src_can_q, done_q;

  bsd_strap_latch u_straps (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .mode(mode), .captured(captured), .capture_now(capture_now)
  );

  bsd_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_uart_sync (
    .clk(clk), .rst_n(rst_n), .din(uart_rx),
    .level(uart_lvl), .fell(uart_fell), .rose(uart_rose)
  );

  bsd_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_can_sync (
    .clk(clk), .rst_n(rst_n), .din(can_rx),
    .level(can_lvl), .fell(can_fell), .rose(can_rose)
  );

  assign watching = (state_q == SEL_WATCH);

  bsd_dom_filter #(.LIMIT(GLITCH_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .enable(watching), .line(can_lvl),
    .line_rose(can_rose), .count(filt_cnt), .saturated(filt_sat),
    .valid_rise(can_valid_rise)
  );

  // UART wins any tie, so the CAN pick needs the UART event to be absent.
  assign pick_uart = watching & uart_fell;
  assign pick_can = watching & can_valid_rise & ~uart_fell;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEL_WAIT: state_d = (decode_straps(strap_hi, strap_lo) == MODE_SBOOT) ? SEL_WATCH : SEL_OFF;
      SEL_WATCH: if (pick_uart || pick_can) state_d = SEL_DONE;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= SEL_WAIT;
      src_uart_q <= 1'b0;
      src_can_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q <= pick_uart | pick_can;
      if (pick_uart) src_uart_q <= 1'b1;
      if (pick_can) src_can_q <= 1'b1;
    end

  assign boot_mode = mode;
  assign fetch_remap = remap_for(mode, sig_ok);
  assign strap_rsvd = captured & (mode == MODE_RSVD);
  assign src_uart = src_uart_q;
  assign src_can = src_can_q;
  assign sel_done = done_q;
endmodule

// File: rtl/boot_src_detect_checker.sv
module boot_src_detect_checker #(
  parameter int CW = 5,
  parameter int GLITCH_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic [1:0] boot_mode,
  input logic captured,
  input logic src_uart,
  input logic src_can,
  input logic sel_done,
  input logic watching,
  input logic uart_fell,
  input logic filt_sat,
  input logic [CW-1:0] filt_cnt
);
  // R1: mode frozen once the straps are captured
  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(boot_mode));

  // R6: no source outside the serial bootstrap mode
  a_r6_idle_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && boot_mode != 2'd1) |-> (!src_uart && !src_can && !sel_done));

  // R10: a UART start while watching always wins
  a_r10_uart_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (watching && uart_fell) |=> (src_uart && !src_can));

  // R9: CAN chosen only after a saturated dominant count
  a_r9_can_needs_filter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_can) |-> $past(filt_sat));

  // R9: filter count never passes its limit
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    filt_cnt <= CW'(GLITCH_CYC));

  // R11: one-hot, latched choice and single-cycle done
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_uart, src_can}));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> !sel_done);
  a_r11_uart_latched: assert property (@(posedge clk) disable iff (!rst_n)
    src_uart |=> src_uart);
  a_r11_can_latched: assert property (@(posedge clk) disable iff (!rst_n)
    src_can |=> src_can);
endmodule

bind boot_src_detect boot_src_detect_checker #(.CW(CW), .GLITCH_CYC(GLITCH_CYC)) u_checker (
  .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .captured(captured),
  .src_uart(src_uart), .src_can(src_can), .sel_done(sel_done),
  .watching(watching), .uart_fell(uart_fell), .filt_sat(filt_sat),
  .filt_cnt(filt_cnt)
);

// File: tb/boot_src_detect_bench.sv
module boot_src_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_hi = 1'b1, strap_lo = 1'b1, sig_ok = 1'b1;
  logic uart_rx = 1'b1, can_rx = 1'b1;
  logic [1:0] boot_mode;
  logic fetch_remap, strap_rsvd, src_uart, src_can, sel_done;
  int n_tests = 0, n_fail = 0;
  int dones = 0;

  always #2 clk = ~clk;

  boot_src_detect u_boot_src_detect (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .sig_ok(sig_ok), .uart_rx(uart_rx), .can_rx(can_rx),
    .boot_mode(boot_mode), .fetch_remap(fetch_remap), .strap_rsvd(strap_rsvd),
    .src_uart(src_uart), .src_can(src_can), .sel_done(sel_done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one rising edge, then settle before sampling; counts done pulses
  task automatic step();
    @(posedge clk);
    #1;
    if (sel_done) dones++;
  endtask

  task automatic restart(input logic hi, input logic lo);
    @(negedge clk);
    rst_n = 1'b0;
    uart_rx = 1'b1;
    can_rx = 1'b1;
    strap_hi = hi;
    strap_lo = lo;
    dones = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();  // strap capture edge
    step();
  endtask

  task automatic can_pulse(input int edges_low);
    @(negedge clk);
    can_rx = 1'b0;
    repeat (edges_low) begin
      @(negedge clk);
      if (sel_done) dones++;
    end
    can_rx = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "src_uart in reset", src_uart, 0);
    check("R11", "src_can in reset", src_can, 0);
    check("R11", "sel_done in reset", sel_done, 0);
  endtask

  task automatic t_user_mode();
    restart(1'b1, 1'b1);
    check("R2", "user mode code", boot_mode, 0);
    check("R2", "user remap", fetch_remap, 0);
    check("R2", "user rsvd flag", strap_rsvd, 0);
    @(negedge clk) uart_rx = 1'b0;
    repeat (5) step();
    can_pulse(30);
    repeat (5) step();
    check("R6", "user mode sources", {src_uart, src_can}, 0);
    check("R6", "user mode done pulses", dones, 0);
  endtask

  task automatic t_alt_mode();
    restart(1'b0, 1'b1);
    check("R4", "alt mode code", boot_mode, 2);
    sig_ok = 1'b1;
    #1 check("R4", "alt remap sig good", fetch_remap, 0);
    sig_ok = 1'b0;
    #1 check("R4", "alt remap sig bad", fetch_remap, 1);
    sig_ok = 1'b1;
    check("R4", "alt rsvd flag", strap_rsvd, 0);
    @(negedge clk) uart_rx = 1'b0;
    repeat (5) step();
    check("R6", "alt mode sources", {src_uart, src_can}, 0);
  endtask

  task automatic t_reserved();
    restart(1'b0, 1'b0);
    check("R5", "reserved code", boot_mode, 3);
    check("R5", "reserved flag", strap_rsvd, 1);
    can_pulse(25);
    repeat (5) step();
    check("R6", "reserved sources", {src_uart, src_can}, 0);
  endtask

  task automatic t_strap_hold();
    restart(1'b1, 1'b0);
    check("R3", "bootstrap code", boot_mode, 1);
    check("R3", "bootstrap remap", fetch_remap, 1);
    @(negedge clk);
    strap_hi = 1'b0;
    strap_lo = 1'b0;
    repeat (4) step();
    check("R1", "mode after strap change", boot_mode, 1);
    check("R1", "rsvd after strap change", strap_rsvd, 0);
  endtask

  task automatic t_uart_pick();
    restart(1'b1, 1'b0);
    @(negedge clk) uart_rx = 1'b0;
    step();  // E
    step();  // E+1
    check("R7", "uart not yet at E+1", src_uart, 0);
    step();  // E+2
    check("R7", "uart chosen at E+2", src_uart, 1);
    check("R7", "done at E+2", sel_done, 1);
    step();
    check("R11", "done lasts one cycle", sel_done, 0);
    @(negedge clk) uart_rx = 1'b1;
    can_pulse(30);
    @(negedge clk) uart_rx = 1'b0;
    repeat (6) step();
    check("R11", "uart kept after activity", {src_uart, src_can}, 2);
    check("R11", "single done pulse", dones, 1);
  endtask

  task automatic t_can_short();
    restart(1'b1, 1'b0);
    can_pulse(19);
    repeat (6) step();
    check("R8", "19-edge glitch ignored", {src_uart, src_can}, 0);
    check("R8", "no done for glitch", dones, 0);
    can_pulse(20);
    step();  // F
    step();  // F+1
    check("R9", "can not yet at F+1", src_can, 0);
    step();  // F+2
    check("R9", "20-edge pulse selects can", src_can, 1);
    check("R9", "done on can pick", sel_done, 1);
    check("R9", "uart stays low", src_uart, 0);
  endtask

  task automatic t_can_long();
    restart(1'b1, 1'b0);
    can_pulse(200);
    repeat (3) step();
    check("R9", "200-edge pulse selects can", src_can, 1);
    @(negedge clk) uart_rx = 1'b0;
    repeat (5) step();
    check("R11", "can kept after uart start", {src_uart, src_can}, 1);
    check("R11", "single done after can", dones, 1);
  endtask

  task automatic t_uart_in_window();
    restart(1'b1, 1'b0);
    @(negedge clk) can_rx = 1'b0;
    repeat (10) @(negedge clk);
    uart_rx = 1'b0;
    repeat (25) @(negedge clk);
    can_rx = 1'b1;
    repeat (5) step();
    check("R10", "uart during can pulse", {src_uart, src_can}, 2);
  endtask

  task automatic t_tie();
    restart(1'b1, 1'b0);
    @(negedge clk) can_rx = 1'b0;
    repeat (25) @(negedge clk);
    can_rx = 1'b1;
    uart_rx = 1'b0;
    repeat (5) step();
    check("R10", "tie goes to uart", {src_uart, src_can}, 2);
    check("R10", "tie single done", dones, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_user_mode();
        t_alt_mode();
        t_reserved();
        t_strap_hold();
        t_uart_pick();
        t_can_short();
        t_can_long();
        t_uart_in_window();
        t_tie();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule